// File: doc/BRIEF.md
# Multi-Sector Erase Sequencer with Suspend

This block runs an erase that may span several sectors of a 16-sector flash array. A decoded sector-erase write places a sector into a selection set and opens a load window measured in microsecond ticks. Every further sector write inside the window adds its sector and starts the window over. When the window runs out, the block works through the selected sectors one at a time. For each sector it first runs a pre-program phase that brings the sector to all zeros, then an erase phase. Sectors that belong to a protected group are skipped.

A suspend request pauses the work. Inside the load window the pause is immediate. During an erase the pause takes effect after a fixed latency. A resume continues the work from where it stopped. The erase length of each sector comes from a programmable tick count. If that count is larger than the internal pulse limit, the block stops in a failed state, which only an abort command clears. When the last sector is finished, the selection mask clears and a one-cycle done pulse is issued.

FSM states and transitions:

| State | Meaning | Transitions |
|---|---|---|
| `ST_IDLE` | nothing selected | to `ST_LOAD` on a sector write |
| `ST_LOAD` | load window open | to `ST_IDLE` on an other-command write or an abort write; stays in `ST_LOAD` on a sector write; to `ST_SUSPENDED` on a suspend write; on window expiry, to `ST_SCAN`, or to `ST_SKIPALL` if every selected sector is protected |
| `ST_SCAN` | pick the next sector | to `ST_PREP` while sectors remain; to `ST_IDLE` (with done) when none remain |
| `ST_PREP` | pre-program phase | to `ST_ERASE` at the end of the phase; to `ST_SUSP_PEND` on a suspend write |
| `ST_ERASE` | erase phase | to `ST_SCAN` at the end of the phase; to `ST_FAIL` at the pulse limit; to `ST_SUSP_PEND` on a suspend write |
| `ST_SUSP_PEND` | suspend latency | to `ST_SUSPENDED` when the latency has run out |
| `ST_SUSPENDED` | paused | on a resume write, back to the state it was paused from |
| `ST_SKIPALL` | short busy interval, nothing to erase | to `ST_IDLE` (with done) |
| `ST_FAIL` | pulse limit exceeded | to `ST_IDLE` on an abort write |

Top module: `seq_erase_ctrl`

## Requirements
- R1: After reset, `sel_mask` is 0 and `window_closed`, `erasing`, `suspended`, `erase_fail` and `done_pulse` are all 0.
- R2: A `sec_wr` in the idle state sets bit `sec_num` of `sel_mask`, where bit i stands for sector i. The block then enters the load window, with `window_closed`=0 and `erasing`=0.
- R3: Each `sec_wr` inside the window ORs its sector into `sel_mask` and starts the window count again from zero.
- R4: The window closes only after WINDOW_TICKS `tick_us` pulses with no new sector write. `window_closed` and `erasing` then go to 1 in the cycle after the last of those ticks.
- R5: An `other_wr` or an `abort_wr` inside the window clears `sel_mask`, returns to idle and starts no erase.
- R6: Each erased sector costs 1 + PREP_TICKS + `erase_len` ticks after the window closes. One cycle after the last sector ends, `done_pulse` is 1 for exactly one cycle, and `sel_mask` is 0 in that same cycle.
- R7: Protection group g covers sectors 2g and 2g+1 and is protected when `prot_grp[g]`=1. Protected sectors that were selected are skipped and use no erase time.
- R8: If every selected sector is protected, `erasing` is 1 for SKIP_TICKS ticks, and then `done_pulse` follows with nothing erased.
- R9: A `suspend_wr` during the pre-program or erase phase raises `suspended`, and clears `erasing`, after SUSP_TICKS ticks. The sector's progress is frozen while the block is suspended.
- R10: A `suspend_wr` inside the load window ends the window and sets `suspended` in the next cycle.
- R11: `resume_wr` has an effect only while `suspended`=1. It then continues the work where it stopped, and a later suspend is accepted again. In any other state it changes nothing.
- R12: If `erase_len` exceeds PULSE_LIMIT, `erase_fail` goes to 1 after PULSE_LIMIT erase ticks and holds until `abort_wr`. The abort clears the flag and `sel_mask`.
- R13: While erasing, `sec_wr`, `other_wr`, `abort_wr` and `resume_wr` are ignored: the mask and the completion time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick_us | input | 1 | one-cycle microsecond time-base pulse |
| sec_wr | input | 1 | decoded sector-erase write strobe |
| sec_num | input | 4 | sector number for `sec_wr` |
| suspend_wr | input | 1 | decoded suspend write strobe |
| resume_wr | input | 1 | decoded resume write strobe |
| other_wr | input | 1 | any other decoded command write |
| abort_wr | input | 1 | decoded reset/abort command write |
| prot_grp | input | 8 | per-group protection bitmap |
| erase_len | input | 16 | erase-phase length per sector, in ticks |
| sel_mask | output | 16 | selected-sector mask |
| window_closed | output | 1 | load window has ended and work is under way |
| erasing | output | 1 | erase sequence actively running |
| suspended | output | 1 | erase suspended |
| erase_fail | output | 1 | pulse limit exceeded |
| done_pulse | output | 1 | one-cycle completion pulse |

## Verification
The bound checker watches several properties on every cycle:
- the done pulse lasts one cycle and coincides with an empty mask;
- the mask only grows while the window is open, and does not change on a sector write during erasing;
- the fail flag holds until an abort;
- the suspended state holds until a resume;
- a suspend in the window takes effect in the next cycle.

Tick-exact timing can only be shown by the directed scenarios. These cover the window length and its restart, the per-sector cost, the skipping of protected groups, the suspend latency, the frozen progress across a suspend, and the point where the fail flag rises.

// File: rtl/seq_erase_pkg.sv
package seq_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SCAN,
        ST_PREP,
        ST_ERASE,
        ST_SUSP_PEND,
        ST_SUSPENDED,
        ST_SKIPALL,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/seq_tick_counter.sv
module seq_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/seq_prot_map.sv
module seq_prot_map #(
    parameter int NUM_SECTORS = 16,
    parameter int PER_GROUP   = 2,
    localparam int NUM_GROUPS = NUM_SECTORS / PER_GROUP
) (
    input  logic [NUM_GROUPS-1:0]  grp,
    output logic [NUM_SECTORS-1:0] sec
);
    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
        assign sec[s] = grp[s / PER_GROUP];
    end
endmodule

// File: rtl/seq_low_pick.sv
module seq_low_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/seq_erase_ctrl.sv
module seq_erase_ctrl
    import seq_erase_pkg::*;
#(
    parameter int NUM_SECTORS  = 16,
    parameter int PER_GROUP    = 2,
    parameter int CNT_W        = 16,
    parameter int WINDOW_TICKS = 80,
    parameter int SUSP_TICKS   = 100,
    parameter int PREP_TICKS   = 4,
    parameter int SKIP_TICKS   = 2,
    parameter int PULSE_LIMIT  = 1000,
    localparam int NUM_GROUPS  = NUM_SECTORS / PER_GROUP,
    localparam int SEC_IDX_W   = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_us,
    input  logic                   sec_wr,
    input  logic [SEC_IDX_W-1:0]   sec_num,
    input  logic                   suspend_wr,
    input  logic                   resume_wr,
    input  logic                   other_wr,
    input  logic                   abort_wr,
    input  logic [NUM_GROUPS-1:0]  prot_grp,
    input  logic [CNT_W-1:0]       erase_len,
    output logic [NUM_SECTORS-1:0] sel_mask,
    output logic                   window_closed,
    output logic                   erasing,
    output logic                   suspended,
    output logic                   erase_fail,
    output logic                   done_pulse
);
    localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WINDOW_TICKS - 1);
    localparam logic [CNT_W-1:0] SUSP_LAST  = CNT_W'(SUSP_TICKS - 1);
    localparam logic [CNT_W-1:0] PREP_LAST  = CNT_W'(PREP_TICKS - 1);
    localparam logic [CNT_W-1:0] SKIP_LAST  = CNT_W'(SKIP_TICKS - 1);
    localparam logic [CNT_W-1:0] LIMIT_VAL  = CNT_W'(PULSE_LIMIT);
    localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(PULSE_LIMIT - 1);

    seq_state_e state_q, state_d, resume_q;

    logic [NUM_SECTORS-1:0] sel_q, pend_q;
    logic [NUM_SECTORS-1:0] prot_sec, unprot_sel, wr_onehot, cur_onehot;
    logic [SEC_IDX_W-1:0]   cur_q, pick_idx;
    logic [CNT_W-1:0]       aux_cnt, op_cnt;
    logic                   aux_clr, op_clr, op_inc;
    logic                   done_q;
    logic                   win_expire, limit_hit, erase_end;

    // ---------------- helpers ----------------
    seq_prot_map #(
        .NUM_SECTORS(NUM_SECTORS),
        .PER_GROUP  (PER_GROUP)
    ) u_prot (
        .grp(prot_grp),
        .sec(prot_sec)
    );

    seq_low_pick #(
        .N (NUM_SECTORS),
        .IW(SEC_IDX_W)
    ) u_pick (
        .vec(pend_q),
        .idx(pick_idx)
    );

    // window / suspend latency / skip interval share one counter
    seq_tick_counter #(.W(CNT_W)) u_aux (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (aux_clr),
        .inc  (tick_us),
        .count(aux_cnt)
    );

    // per-sector phase progress, frozen while suspended
    seq_tick_counter #(.W(CNT_W)) u_op (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (op_clr),
        .inc  (op_inc),
        .count(op_cnt)
    );

    assign wr_onehot  = NUM_SECTORS'(1) << sec_num;
    assign cur_onehot = NUM_SECTORS'(1) << cur_q;
    assign unprot_sel = sel_q & ~prot_sec;
    assign win_expire = tick_us && (aux_cnt == WIN_LAST);
    assign limit_hit  = (erase_len > LIMIT_VAL) && (op_cnt == LIMIT_LAST);
    assign erase_end  = ({1'b0, op_cnt} + 1'b1) >= {1'b0, erase_len};

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sec_wr) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (other_wr || abort_wr) state_d = ST_IDLE;
                else if (sec_wr)          state_d = ST_LOAD;
                else if (suspend_wr)      state_d = ST_SUSPENDED;
                else if (win_expire)      state_d = (unprot_sel == '0) ? ST_SKIPALL : ST_SCAN;
            end
            ST_SCAN: begin
                state_d = (pend_q == '0) ? ST_IDLE : ST_PREP;
            end
            ST_PREP: begin
                if (suspend_wr)                             state_d = ST_SUSP_PEND;
                else if (tick_us && (op_cnt == PREP_LAST))  state_d = ST_ERASE;
            end
            ST_ERASE: begin
                if (suspend_wr)                state_d = ST_SUSP_PEND;
                else if (tick_us && limit_hit) state_d = ST_FAIL;
                else if (tick_us && erase_end) state_d = ST_SCAN;
            end
            ST_SUSP_PEND: begin
                if (tick_us && (aux_cnt == SUSP_LAST)) state_d = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (resume_wr) state_d = resume_q;
            end
            ST_SKIPALL: begin
                if (tick_us && (aux_cnt == SKIP_LAST)) state_d = ST_IDLE;
            end
            ST_FAIL: begin
                if (abort_wr) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign aux_clr = (state_d != state_q) || ((state_q == ST_LOAD) && sec_wr);
    assign op_clr  = (state_q == ST_SCAN) || ((state_q == ST_PREP) && (state_d == ST_ERASE));
    assign op_inc  = tick_us && (state_d == state_q) &&
                     ((state_q == ST_PREP) || (state_q == ST_ERASE));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- sector bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            pend_q   <= '0;
            cur_q    <= '0;
            resume_q <= ST_SCAN;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (sec_wr) sel_q <= wr_onehot;
                end
                ST_LOAD: begin
                    if (other_wr || abort_wr) begin
                        sel_q <= '0;
                    end else if (sec_wr) begin
                        sel_q <= sel_q | wr_onehot;
                    end else if (state_d != ST_LOAD) begin
                        pend_q   <= unprot_sel;
                        resume_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pend_q == '0) begin
                        sel_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        cur_q <= pick_idx;
                    end
                end
                ST_PREP, ST_ERASE: begin
                    if (state_d == ST_SUSP_PEND) resume_q <= state_q;
                    if ((state_q == ST_ERASE) && (state_d == ST_SCAN)) pend_q <= pend_q & ~cur_onehot;
                end
                ST_SKIPALL: begin
                    if (state_d == ST_IDLE) begin
                        sel_q  <= '0;
                        done_q <= 1'b1;
                    end
                end
                ST_FAIL: begin
                    if (abort_wr) begin
                        sel_q  <= '0;
                        pend_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sel_mask      = sel_q;
        done_pulse    = done_q;
        window_closed = !((state_q == ST_IDLE) || (state_q == ST_LOAD));
        erasing       = (state_q == ST_SCAN) || (state_q == ST_PREP) || (state_q == ST_ERASE) ||
                        (state_q == ST_SUSP_PEND) || (state_q == ST_SKIPALL);
        suspended     = (state_q == ST_SUSPENDED);
        erase_fail    = (state_q == ST_FAIL);
    end

endmodule

// File: rtl/seq_erase_chk.sv
module seq_erase_chk #(
    parameter int NUM_SECTORS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sec_wr,
    input logic                   suspend_wr,
    input logic                   resume_wr,
    input logic                   other_wr,
    input logic                   abort_wr,
    input logic [NUM_SECTORS-1:0] sel_mask,
    input logic                   window_closed,
    input logic                   erasing,
    input logic                   suspended,
    input logic                   erase_fail,
    input logic                   done_pulse
);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R6
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (sel_mask == '0));

    // R6
    busy_has_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erasing |-> (sel_mask != '0));

    // R3
    mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_closed && (sel_mask != '0) && !other_wr && !abort_wr)
        |=> ((sel_mask & $past(sel_mask)) == $past(sel_mask)));

    // R13
    busy_ignore_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing && sec_wr) |=> ((sel_mask == $past(sel_mask)) || done_pulse));

    // R12
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_fail && !abort_wr) |=> erase_fail);

    // R11
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !resume_wr) |=> suspended);

    // R10
    win_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_closed && (sel_mask != '0) && suspend_wr && !sec_wr && !other_wr && !abort_wr)
        |=> suspended);
endmodule

bind seq_erase_ctrl seq_erase_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_wr       (sec_wr),
    .suspend_wr   (suspend_wr),
    .resume_wr    (resume_wr),
    .other_wr     (other_wr),
    .abort_wr     (abort_wr),
    .sel_mask     (sel_mask),
    .window_closed(window_closed),
    .erasing      (erasing),
    .suspended    (suspended),
    .erase_fail   (erase_fail),
    .done_pulse   (done_pulse)
);

// File: tb/seq_erase_ctrl_tb.sv
`timescale 1ns/1ps
module seq_erase_ctrl_tb;
    localparam int W  = 4;   // window ticks
    localparam int SP = 3;   // suspend latency
    localparam int PR = 2;   // pre-program ticks
    localparam int SK = 2;   // skip interval
    localparam int LIM = 20; // pulse limit

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b1;
    logic        sec_wr = 1'b0;
    logic [3:0]  sec_num = '0;
    logic        suspend_wr = 1'b0, resume_wr = 1'b0, other_wr = 1'b0, abort_wr = 1'b0;
    logic [7:0]  prot_grp = '0;
    logic [15:0] erase_len = 16'd3;
    logic [15:0] sel_mask;
    logic        window_closed, erasing, suspended, erase_fail, done_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seq_erase_ctrl #(
        .WINDOW_TICKS(W), .SUSP_TICKS(SP), .PREP_TICKS(PR),
        .SKIP_TICKS(SK), .PULSE_LIMIT(LIM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .sec_wr(sec_wr), .sec_num(sec_num),
        .suspend_wr(suspend_wr), .resume_wr(resume_wr),
        .other_wr(other_wr), .abort_wr(abort_wr),
        .prot_grp(prot_grp), .erase_len(erase_len),
        .sel_mask(sel_mask), .window_closed(window_closed), .erasing(erasing),
        .suspended(suspended), .erase_fail(erase_fail), .done_pulse(done_pulse)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_sec(int n);
        sec_num = 4'(n); sec_wr = 1'b1; @(negedge clk); sec_wr = 1'b0;
    endtask
    task automatic pulse_susp();   suspend_wr = 1'b1; @(negedge clk); suspend_wr = 1'b0; endtask
    task automatic pulse_resume(); resume_wr = 1'b1;  @(negedge clk); resume_wr = 1'b0;  endtask
    task automatic pulse_other();  other_wr = 1'b1;   @(negedge clk); other_wr = 1'b0;   endtask
    task automatic pulse_abort();  abort_wr = 1'b1;   @(negedge clk); abort_wr = 1'b0;   endtask

    task automatic wait_until(int t0, int n);
        while (cyc - t0 < n) @(negedge clk);
    endtask

    task automatic wait_done(int t0, output int el);
        el = -1;
        for (int i = 0; i < 300; i++) begin
            if (done_pulse) begin el = cyc - t0; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check_eq("R1", "sel_mask", int'(sel_mask), 0);
        check_eq("R1", "flags", int'({window_closed, erasing, suspended, erase_fail, done_pulse}), 0);
    endtask

    task automatic t_single();
        int t0, el;
        tick_us = 1'b0;
        pulse_sec(5);
        check_eq("R2", "mask after entry", int'(sel_mask), 16'h0020);
        check_eq("R2", "window_closed in window", int'(window_closed), 0);
        repeat (10) @(negedge clk);
        check_eq("R4", "no expiry without ticks", int'(erasing), 0);
        tick_us = 1'b1; t0 = cyc;
        wait_until(t0, W - 1);
        check_eq("R4", "window open one tick early", int'(window_closed), 0);
        wait_until(t0, W);
        check_eq("R4", "window closed on time", int'(window_closed), 1);
        wait_done(t0, el);
        check_eq("R6", "one-sector done time", el, W + 1 + PR + 3 + 1);
        check_eq("R6", "mask clear at done", int'(sel_mask), 0);
        @(negedge clk);
        check_eq("R6", "done single cycle", int'(done_pulse), 0);
    endtask

    task automatic t_append();
        int t0, el;
        pulse_sec(0);
        repeat (2) @(negedge clk);
        pulse_sec(7); t0 = cyc;
        check_eq("R3", "appended mask", int'(sel_mask), 16'h0081);
        wait_until(t0, W - 1);
        check_eq("R3", "window restarted", int'(window_closed), 0);
        wait_done(t0, el);
        check_eq("R6", "two-sector done time", el, W + 2 * (1 + PR + 3) + 1);
    endtask

    task automatic t_cancel();
        pulse_sec(3);
        pulse_other();
        check_eq("R5", "mask after other cmd", int'(sel_mask), 0);
        repeat (W + 4) @(negedge clk);
        check_eq("R5", "no erase after cancel", int'({erasing, window_closed}), 0);
        pulse_sec(9);
        pulse_abort();
        check_eq("R5", "mask after abort cmd", int'(sel_mask), 0);
    endtask

    task automatic t_protect();
        int t0, el;
        prot_grp = 8'b0000_0010; // group 1 = sectors 2,3
        pulse_sec(2); pulse_sec(3); pulse_sec(5); t0 = cyc;
        check_eq("R7", "mask holds protected too", int'(sel_mask), 16'h002C);
        wait_done(t0, el);
        check_eq("R7", "only unprotected sector timed", el, W + (1 + PR + 3) + 1);
        prot_grp = '0;
    endtask

    task automatic t_allprot();
        int t0, el;
        prot_grp = 8'b1000_0000;
        pulse_sec(14); pulse_sec(15); t0 = cyc;
        wait_until(t0, W + 1);
        check_eq("R8", "busy during skip", int'(erasing), 1);
        wait_done(t0, el);
        check_eq("R8", "skip done time", el, W + SK);
        prot_grp = '0;
    endtask

    task automatic t_win_susp();
        int t0, el;
        pulse_sec(4);
        pulse_susp();
        check_eq("R10", "suspended next cycle", int'(suspended), 1);
        check_eq("R10", "window ended", int'(window_closed), 1);
        repeat (6) @(negedge clk);
        check_eq("R11", "stays suspended", int'({suspended, done_pulse}), 2);
        pulse_resume(); t0 = cyc;
        check_eq("R11", "resume clears suspend", int'(suspended), 0);
        wait_done(t0, el);
        check_eq("R11", "done after resume", el, (1 + PR + 3) + 1);
    endtask

    task automatic t_erase_susp();
        int t0, t1, el;
        erase_len = 16'd10;
        pulse_sec(1); t0 = cyc;
        wait_until(t0, 8);
        pulse_susp(); t1 = cyc;
        wait_until(t1, SP - 1);
        check_eq("R9", "still erasing in latency", int'({erasing, suspended}), 2);
        wait_until(t1, SP);
        check_eq("R9", "suspended after latency", int'({erasing, suspended}), 1);
        repeat (5) @(negedge clk);
        check_eq("R9", "held while suspended", int'(suspended), 1);
        pulse_resume(); t1 = cyc;
        wait_until(t1, 3);
        pulse_susp(); t1 = cyc;
        wait_until(t1, SP);
        check_eq("R11", "second suspend accepted", int'(suspended), 1);
        pulse_resume(); t1 = cyc;
        wait_done(t1, el);
        check_eq("R9", "frozen progress resumes", el, 7);
        erase_len = 16'd3;
    endtask

    task automatic t_ignore();
        int t0, el;
        pulse_resume();
        check_eq("R11", "resume idle no effect", int'({suspended, window_closed, erasing}), 0);
        pulse_sec(8); t0 = cyc;
        wait_until(t0, 6);
        pulse_other(); pulse_abort(); pulse_sec(9); pulse_resume();
        check_eq("R13", "mask unchanged while erasing", int'(sel_mask), 16'h0100);
        wait_done(t0, el);
        check_eq("R13", "done time unchanged", el, W + 1 + PR + 3 + 1);
    endtask

    task automatic t_fail();
        int t0;
        erase_len = 16'd30;
        pulse_sec(6); t0 = cyc;
        wait_until(t0, W + 1 + PR + LIM - 1);
        check_eq("R12", "no fail before limit", int'(erase_fail), 0);
        wait_until(t0, W + 1 + PR + LIM);
        check_eq("R12", "fail at limit", int'(erase_fail), 1);
        pulse_sec(9);
        repeat (3) @(negedge clk);
        check_eq("R12", "fail held", int'(erase_fail), 1);
        check_eq("R12", "mask held in fail", int'(sel_mask), 16'h0040);
        pulse_abort();
        check_eq("R12", "abort clears", int'({erase_fail, erasing}), 0);
        check_eq("R12", "abort clears mask", int'(sel_mask), 0);
        erase_len = 16'd3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_append();
        t_cancel();
        t_protect();
        t_allprot();
        t_win_susp();
        t_erase_susp();
        t_ignore();
        t_fail();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule